// File: doc/BRIEF.md
# Transmit DMA Channel Enable and Interrupt Register Block

This block holds the control and interrupt state for a transmit DMA engine with a configurable number of channel slots. Software turns channels on through one write address and off through another. Each write touches only the slots whose bits are 1, so no read-modify-write is needed. The resulting enable bitmap is driven to the data-movement logic on `chan_en`. That logic is outside this block, as are the descriptor rings.

Each slot reports two kinds of event: a descriptor finished with a notify request, and an error. Each slot keeps a sticky status word that is cleared by writing 1 to a bit. A mask word next to it selects which status bits may interrupt. A summary word gives one bit per slot with a pending unmasked cause, and `irq` is the OR of that word. To halt a slot, software clears its enable bit and writes zero to its mask. Register reads are combinational from the current state.

Register map (byte addresses):

| Address | Meaning |
|---|---|
| 0x0 | enable set (write 1 to set); reads the bitmap |
| 0x4 | enable clear (write 1 to clear); reads the bitmap |
| 0x34 | interrupt summary (read only) |
| 0x8000 + k·0x400 + 0x14 | status of slot k |
| 0x8000 + k·0x400 + 0x24 | mask of slot k |

Top module: `dmaintc_top`

## Requirements
- R1: After reset the enable bitmap, every status word, every mask word and the summary read as 0, and `irq` is 0.
- R2: A write to 0x0 sets every enable bit k whose write-data bit k is 1 and leaves the other enable bits unchanged. Reads of 0x0 and 0x4 return the bitmap in bits N-1:0, and `chan_en` carries the same value.
- R3: A write to 0x4 clears every enable bit k whose write-data bit k is 1 and leaves the other enable bits unchanged.
- R4: A `done_evt[k]` pulse sets status bit 0 of slot k only while enable bit k is 1. While the slot is disabled the pulse is ignored.
- R5: An `err_evt[k]` pulse sets status bit 6 of slot k whether or not the slot is enabled.
- R6: A write to a status word clears each of bits 0 and 6 for which the write-data bit is 1. Bits written 0 keep their value. All other status bits read 0.
- R7: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: A write to a mask word stores write-data bits 0 and 6. All other mask bits read 0. A mask bit of 1 lets the status bit at the same position interrupt.
- R9: Summary bit k (address 0x34) is 1 exactly when slot k has a status bit at 1 whose mask bit is also 1. Status bits latch while they are masked.
- R10: `irq` is the OR of the summary bits. Unmasking a status bit that is already set raises `irq` right after the clock edge that stores the mask write.
- R11: Writes to unmapped addresses, to slots k >= N, or to the summary address change no state. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (17) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| done_evt | input | N_CH | Per-slot descriptor-done-with-notify pulse |
| err_evt | input | N_CH | Per-slot error pulse |
| chan_en | output | N_CH | Enable bitmap to the data path |
| irq | output | 1 | Combined interrupt request |

## Verification
All state changes happen at the rising edge that samples a write strobe or an event pulse. Because reads, the summary and `irq` are combinational from that state, every result is due one cycle after its stimulus, with no further delay. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then reads back every register, plus `chan_en` and `irq`, at the next falling edge and compares them with a model updated for that same cycle. In the same-cycle collision case the write and the event are applied together, and the status is checked one edge later.

// File: rtl/dmaintc_pkg.sv
// Package: address map and bit positions shared by the register block.
// Assumes byte addresses and 32-bit register words.
package dmaintc_pkg;
    localparam int unsigned OFS_EN_SET   = 32'h0000_0000;
    localparam int unsigned OFS_EN_CLR   = 32'h0000_0004;
    localparam int unsigned OFS_SUMMARY  = 32'h0000_0034;
    localparam int unsigned SLOT_BASE    = 32'h0000_8000;
    localparam int unsigned SLOT_SHIFT   = 10;           // 0x400 stride
    localparam int unsigned SLOT_OFS_ST  = 32'h0000_0014;
    localparam int unsigned SLOT_OFS_MK  = 32'h0000_0024;
    localparam int unsigned BIT_DONE     = 0;
    localparam int unsigned BIT_ERR      = 6;
    localparam int unsigned WORD_W       = 32;
endpackage

// File: rtl/dmaintc_decode.sv
// Module: address decoder. Turns a byte address into one-hot register hits.
// Assumes N_CH <= 2**(ADDR_W-SLOT_SHIFT) and ADDR_W > SLOT_SHIFT.
module dmaintc_decode
    import dmaintc_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_set,
    output logic              hit_clr,
    output logic              hit_sum,
    output logic [N_CH-1:0]   hit_st,
    output logic [N_CH-1:0]   hit_mk
);
    localparam int IDX_W = ADDR_W - SLOT_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic              in_slots;

    // Global registers and slot-window offset.
    always_comb begin
        hit_set  = (addr == ADDR_W'(OFS_EN_SET));
        hit_clr  = (addr == ADDR_W'(OFS_EN_CLR));
        hit_sum  = (addr == ADDR_W'(OFS_SUMMARY));
        in_slots = (addr >= ADDR_W'(SLOT_BASE));
        rel      = addr - ADDR_W'(SLOT_BASE);
    end

    // One hit pair per slot.
    for (genvar k = 0; k < N_CH; k++) begin : g_slot_hit
        always_comb begin
            hit_st[k] = in_slots && (rel[ADDR_W-1:SLOT_SHIFT] == IDX_W'(k))
                        && (rel[SLOT_SHIFT-1:0] == SLOT_SHIFT'(SLOT_OFS_ST));
            hit_mk[k] = in_slots && (rel[ADDR_W-1:SLOT_SHIFT] == IDX_W'(k))
                        && (rel[SLOT_SHIFT-1:0] == SLOT_SHIFT'(SLOT_OFS_MK));
        end
    end
endmodule

// File: rtl/dmaintc_slot.sv
// Module: interrupt state for one channel slot. It holds sticky status bits
// (done, error), cleared by writing 1, and the matching mask bits.
// Assumes event pulses come from the same clock domain. A new event
// outranks a clear that arrives in the same cycle.
module dmaintc_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic done_in,
    input  logic err_in,
    input  logic st_we,
    input  logic mk_we,
    input  logic wd_done,
    input  logic wd_err,
    output logic st_done,
    output logic st_err,
    output logic mk_done,
    output logic mk_err,
    output logic pend
);
    // Status bits: a set from an event wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_err  <= 1'b0;
        end else begin
            st_done <= (done_in && enabled) || (st_done && !(st_we && wd_done));
            st_err  <= err_in || (st_err && !(st_we && wd_err));
        end
    end

    // Mask bits: plain write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mk_done <= 1'b0;
            mk_err  <= 1'b0;
        end else if (mk_we) begin
            mk_done <= wd_done;
            mk_err  <= wd_err;
        end
    end

    // Pending cause for the summary register.
    always_comb pend = (st_done && mk_done) || (st_err && mk_err);
endmodule

// File: rtl/dmaintc_top.sv
// Module: enable and interrupt register block for a transmit DMA engine.
// It keeps the enable bitmap (separate set and clear addresses), the slot
// status and mask words, the summary word and the combined interrupt.
// Assumes N_CH <= 32 and a single-cycle write strobe. Reads are combinational.
module dmaintc_top
    import dmaintc_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [N_CH-1:0]     done_evt,
    input  logic [N_CH-1:0]     err_evt,
    output logic [N_CH-1:0]     chan_en,
    output logic                irq
);
    logic            hit_set, hit_clr, hit_sum;
    logic [N_CH-1:0] hit_st, hit_mk;
    logic [N_CH-1:0] st_done_v, st_err_v, mk_done_v, mk_err_v, pend_v;
    logic [N_CH-1:0] en_q;
    logic            unused_wdata;

    dmaintc_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .hit_set (hit_set),
        .hit_clr (hit_clr),
        .hit_sum (hit_sum),
        .hit_st  (hit_st),
        .hit_mk  (hit_mk)
    );

    // Enable bitmap: set and clear through their own addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_q <= '0;
        else if (bus_wr && hit_set) en_q <= en_q | bus_wdata[N_CH-1:0];
        else if (bus_wr && hit_clr) en_q <= en_q & ~bus_wdata[N_CH-1:0];
    end

    // One interrupt slot per channel.
    for (genvar k = 0; k < N_CH; k++) begin : g_slot
        dmaintc_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .enabled (en_q[k]),
            .done_in (done_evt[k]),
            .err_in  (err_evt[k]),
            .st_we   (bus_wr && hit_st[k]),
            .mk_we   (bus_wr && hit_mk[k]),
            .wd_done (bus_wdata[BIT_DONE]),
            .wd_err  (bus_wdata[BIT_ERR]),
            .st_done (st_done_v[k]),
            .st_err  (st_err_v[k]),
            .mk_done (mk_done_v[k]),
            .mk_err  (mk_err_v[k]),
            .pend    (pend_v[k])
        );
    end

    // Outputs to the data path and the interrupt line.
    always_comb begin
        chan_en      = en_q;
        irq          = |pend_v;
        unused_wdata = ^bus_wdata;
    end

    // Read multiplexer: zero for any address without a register.
    always_comb begin
        bus_rdata = '0;
        if (hit_set || hit_clr) bus_rdata[N_CH-1:0] = en_q;
        if (hit_sum)            bus_rdata[N_CH-1:0] = pend_v;
        for (int k = 0; k < N_CH; k++) begin
            if (hit_st[k]) begin
                bus_rdata[BIT_DONE] = st_done_v[k];
                bus_rdata[BIT_ERR]  = st_err_v[k];
            end
            if (hit_mk[k]) begin
                bus_rdata[BIT_DONE] = mk_done_v[k];
                bus_rdata[BIT_ERR]  = mk_err_v[k];
            end
        end
    end
endmodule

// File: rtl/dmaintc_chk.sv
// Module: property checker for dmaintc_top, attached by bind. It watches
// the bus, the event inputs and the slot state across clock edges.
module dmaintc_chk #(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [N_CH-1:0]   done_evt,
    input logic [N_CH-1:0]   err_evt,
    input logic [N_CH-1:0]   chan_en,
    input logic [N_CH-1:0]   st_done,
    input logic [N_CH-1:0]   st_err,
    input logic [N_CH-1:0]   mk_done,
    input logic [N_CH-1:0]   mk_err,
    input logic              irq
);
    for (genvar k = 0; k < N_CH; k++) begin : g_k
        // R2
        en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[k]) |=> chan_en[k]);
        // R3
        en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[k]) |=> !chan_en[k]);
        // R4
        done_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!chan_en[k] && !st_done[k]) |=> !st_done[k]);
        // R5
        err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_evt[k] |=> st_err[k]);
        // R7
        done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_evt[k] && chan_en[k]) |=> st_done[k]);
        // R10
        irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((st_err[k] && mk_err[k]) || (st_done[k] && mk_done[k])) |-> irq);
    end
    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_done & mk_done) == '0 && (st_err & mk_err) == '0) |-> !irq);
endmodule

bind dmaintc_top dmaintc_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .chan_en   (chan_en),
    .st_done   (st_done_v),
    .st_err    (st_err_v),
    .mk_done   (mk_done_v),
    .mk_err    (mk_err_v),
    .irq       (irq)
);

// File: tb/dmaintc_top_bench.sv
// Bench: sweeps over four slots, with the expected state held in a model
// that is updated from the requirements.
module dmaintc_top_bench;
    localparam int PERIOD = 10;
    localparam int NC     = 4;
    localparam int AW     = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] done_evt = '0;
    logic [NC-1:0] err_evt = '0;
    logic [NC-1:0] chan_en;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [NC-1:0] m_en = '0;
    logic [NC-1:0] m_d = '0, m_e = '0, m_md = '0, m_me = '0;

    always #(PERIOD/2) clk = ~clk;

    dmaintc_top #(.N_CH(NC), .ADDR_W(AW)) u_dmaintc_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_evt(done_evt),
        .err_evt(err_evt), .chan_en(chan_en), .irq(irq)
    );

    function automatic logic [AW-1:0] st_a(int k);
        return AW'(32'h8014 + k * 32'h400);
    endfunction
    function automatic logic [AW-1:0] mk_a(int k);
        return AW'(32'h8024 + k * 32'h400);
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(string tag, logic [AW-1:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        cmp(tag, bus_rdata, exp);
    endtask

    // Compare every register, chan_en and irq with the model.
    task automatic check_all(string tag);
        logic [NC-1:0] sum;
        sum = (m_d & m_md) | (m_e & m_me);
        rd({tag, " en@0"}, AW'(0), 32'(m_en));
        rd({tag, " en@4"}, AW'(4), 32'(m_en));
        cmp({tag, " chan_en"}, 32'(chan_en), 32'(m_en));
        rd({tag, " summary"}, AW'(32'h34), 32'(sum));
        cmp({tag, " irq"}, 32'(irq), 32'(|sum));
        for (int k = 0; k < NC; k++) begin
            rd({tag, " status"}, st_a(k), (32'(m_d[k]) << 0) | (32'(m_e[k]) << 6));
            rd({tag, " mask"}, mk_a(k), (32'(m_md[k]) << 0) | (32'(m_me[k]) << 6));
        end
    endtask

    // One clock: optional write plus event pulses. The model applies the clear first, then the events.
    task automatic step(bit w, logic [AW-1:0] a, logic [31:0] d,
                        logic [NC-1:0] dv, logic [NC-1:0] ev);
        logic [NC-1:0] en_before;
        en_before = m_en;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        done_evt = dv; err_evt = ev;
        if (w) begin
            if (a == AW'(0)) m_en = m_en | d[NC-1:0];
            if (a == AW'(4)) m_en = m_en & ~d[NC-1:0];
            for (int k = 0; k < NC; k++) begin
                if (a == st_a(k)) begin
                    if (d[0]) m_d[k] = 1'b0;
                    if (d[6]) m_e[k] = 1'b0;
                end
                if (a == mk_a(k)) begin
                    m_md[k] = d[0];
                    m_me[k] = d[6];
                end
            end
        end
        m_d = m_d | (dv & en_before);
        m_e = m_e | ev;
        @(negedge clk);
        bus_wr = 1'b0; done_evt = '0; err_evt = '0;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");

        // R2: set sweep from an empty bitmap, then accumulation
        for (int p = 0; p < 16; p++) begin
            step(1, AW'(4), 32'hF, '0, '0);
            step(1, AW'(0), 32'(p), '0, '0);
            check_all("R2");
        end
        step(1, AW'(4), 32'hF, '0, '0);
        step(1, AW'(0), 32'h1, '0, '0);
        step(1, AW'(0), 32'h4, '0, '0);
        check_all("R2 accumulate");

        // R3: clear sweep from a full bitmap
        for (int q = 0; q < 16; q++) begin
            step(1, AW'(0), 32'hF, '0, '0);
            step(1, AW'(4), 32'(q), '0, '0);
            check_all("R3");
        end

        // R4: done events while disabled, then under a partial enable
        step(1, AW'(4), 32'hF, '0, '0);
        step(0, '0, '0, 4'hF, '0);
        check_all("R4 disabled");
        step(1, AW'(0), 32'h5, '0, '0);
        step(0, '0, '0, 4'hF, '0);
        check_all("R4 partial");

        // R5: errors latch on any slot; R9: masked causes stay off the summary
        step(0, '0, '0, '0, 4'hF);
        check_all("R5 R9 masked");

        // R8 R9 R10: mask sweep over every slot combination
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < NC; k++)
                step(1, mk_a(k), m[k] ? 32'h41 : 32'h0, '0, '0);
            check_all("R9 R10 sweep");
        end
        step(1, mk_a(2), 32'hFFFF_FFFF, '0, '0);
        check_all("R8 unused bits");

        // R10: unmask a single pending error; irq is due after one edge
        for (int k = 0; k < NC; k++) step(1, mk_a(k), 32'h0, '0, '0);
        check_all("R10 all masked");
        step(1, mk_a(3), 32'h40, '0, '0);
        check_all("R10 unmask");

        // R6: write-1-to-clear, one bit at a time, and a write of zero
        step(1, st_a(0), 32'h0, '0, '0);
        check_all("R6 zero write");
        step(1, st_a(0), 32'h01, '0, '0);
        check_all("R6 clear done");
        step(1, st_a(3), 32'h40, '0, '0);
        check_all("R6 clear err");

        // R7: event and clear in the same cycle
        step(1, st_a(2), 32'h41, 4'h4, 4'h4);
        check_all("R7 collision");
        step(1, st_a(1), 32'h40, '0, 4'h2);
        check_all("R7 err collision");

        // R11: stray writes leave every register unchanged
        step(1, AW'(32'h8000 + 4 * 32'h400 + 32'h14), 32'h41, '0, '0);
        step(1, AW'(32'h8000 + 4 * 32'h400 + 32'h24), 32'h41, '0, '0);
        step(1, AW'(32'h34), 32'hFFFF_FFFF, '0, '0);
        step(1, AW'(32'h8), 32'hFFFF_FFFF, '0, '0);
        step(1, AW'(32'h8018), 32'hFFFF_FFFF, '0, '0);
        check_all("R11 stray writes");
        rd("R11 read slot4", AW'(32'h9014), 32'h0);
        rd("R11 read unmapped", AW'(32'h8), 32'h0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule